// File: doc/BRIEF.md
# Masked Control Word with Clear and Set Write Ports

This block holds one 64-bit control/status word. A simple word-addressed request channel reaches it at three word offsets, all backed by the same storage. The first offset loads the written value as it is. The second ANDs the write data into the current value, so it clears bits. The third ORs the write data into the current value, so it sets bits. Only the top 16 bits are stored. Everything below them reads as zero.

The most significant stored bit drives a level interrupt output. Software uses the set offset to raise the interrupt, and the clear offset to drop it, without a read-modify-write. The request carries a byte address, which is shifted right by three to give the word offset, and a byte count. Only full 8-byte accesses are honoured.

An access to an offset the block does not decode, or an access with any other byte count, leaves the word unchanged and pulses an error flag for one cycle. Reads answer on a registered response channel. The channel holds a response until the consumer accepts it. While that response waits, it stalls the request channel.

Top module: `misc_ctl_reg`

## Requirements
- R1: The word offset is the byte address shifted right by 3, so address bits 2..0 are ignored. The plain word sits at offset 0x4020, the clear port at 0x4021 and the set port at 0x4022.
- R2: An accepted 8-byte write to offset 0x4020 loads the write data, masked as in R3.
- R3: After every write, stored bits 47..0 are zero, so only bits 63..48 are retained and read back.
- R4: An accepted 8-byte write to offset 0x4021 stores the current value ANDed with the write data.
- R5: An accepted 8-byte write to offset 0x4022 stores the current value ORed with the write data.
- R6: `irq` equals stored bit 63. It changes only in the cycle after an accepted write, never otherwise.
- R7: An accepted read raises `rsp_valid` in the next cycle. The returned data is the stored value for an 8-byte read of offset 0x4020, and zero for every other offset, including 0x4021 and 0x4022, or for any other byte count.
- R8: An accepted access whose offset is outside 0x4020..0x4022, or whose `req_size` is not 8, raises `err_flag` for exactly the next cycle and leaves the stored value unchanged.
- R9: A response held with `rsp_ready` low keeps `rsp_valid` high and `rsp_rdata` stable. While that holds, `req_ready` is low. Otherwise `req_ready` is high, and a request is accepted when `req_valid` and `req_ready` are both high.
- R10: After reset the stored value is zero, `irq` and `err_flag` are low, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 24 | Byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, big-endian word view |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 64 | Read response data |
| err_flag | output | 1 | One-cycle pulse for an unsupported access |
| irq | output | 1 | Level interrupt from stored bit 63 |

## Verification
A directed sequence first writes all ones to the plain offset, which shows the low-bit mask. It then clears bit 63 through the clear port and sets it again through the set port, which tells the three write kinds apart because each leaves a different value and `irq` level. Reads of the two write ports, writes to neighbouring offsets and writes with a 4-byte count separate the decoded offsets from the rest. A held response shows that back-pressure keeps data stable and blocks new requests. A long pseudo-random run then mixes offsets, sizes, address low bits and `rsp_ready` stalls, and a behavioural model is compared against the block on every clock.

// File: rtl/misc_reg_pkg.sv
package misc_reg_pkg;
  typedef enum logic [1:0] {
    WOP_NONE = 2'd0,
    WOP_LOAD = 2'd1,
    WOP_CLR  = 2'd2,
    WOP_SET  = 2'd3
  } wr_op_e;

  function automatic logic [63:0] keep_top_mask(input int data_w, input int keep_w);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < data_w && i >= data_w - keep_w) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/misc_addr_decode.sv
module misc_addr_decode
  import misc_reg_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SIZE_W   = 4,
  parameter int WORD_B   = 8,
  parameter int BASE_OFF = 32'h4020
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              write,
  output logic              hit_plain,
  output logic              bad_access,
  output wr_op_e            op
);
  localparam int SHIFT = $clog2(WORD_B);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_OFF);

  logic [ADDR_W-1:0] word_off;
  logic [ADDR_W-1:0] rel;
  logic              size_ok;
  logic              mapped;

  always_comb begin
    word_off   = addr >> SHIFT;
    rel        = word_off - BASE;
    size_ok    = (size == SIZE_W'(WORD_B));
    mapped     = (word_off >= BASE) && (rel < ADDR_W'(3));
    hit_plain  = size_ok && (rel == '0) && mapped;
    bad_access = !(size_ok && mapped);
    op         = WOP_NONE;
    if (write && size_ok && mapped) begin
      unique case (rel[1:0])
        2'd0:    op = WOP_LOAD;
        2'd1:    op = WOP_CLR;
        2'd2:    op = WOP_SET;
        default: op = WOP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/misc_store.sv
module misc_store
  import misc_reg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_op_e            op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic              irq
);
  localparam logic [63:0] MASK64 = keep_top_mask(DATA_W, KEEP_W);
  localparam logic [DATA_W-1:0] MASK = MASK64[DATA_W-1:0];

  logic [DATA_W-1:0] nxt;

  always_comb begin
    unique case (op)
      WOP_LOAD: nxt = wdata & MASK;
      WOP_CLR:  nxt = value & wdata & MASK;
      WOP_SET:  nxt = (value | wdata) & MASK;
      default:  nxt = value;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else     value <= nxt;
  end

  assign irq = value[DATA_W-1];
endmodule

// File: rtl/misc_rsp.sv
module misc_rsp #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_acc,
  input  logic              rd_hit,
  input  logic              bad_acc,
  input  logic [DATA_W-1:0] value,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err_flag  <= 1'b0;
    end else begin
      err_flag <= bad_acc;
      if (rd_acc) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_hit ? value : '0;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/misc_ctl_reg.sv
module misc_ctl_reg
  import misc_reg_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SIZE_W   = 4,
  parameter int DATA_W   = 64,
  parameter int KEEP_W   = 16,
  parameter int BASE_OFF = 32'h4020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err_flag,
  output logic              irq
);
  localparam int WORD_B = DATA_W / 8;

  logic              acc;
  logic              hit_plain;
  logic              bad_access;
  wr_op_e            dec_op;
  wr_op_e            st_op;
  logic [DATA_W-1:0] reg_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign st_op     = acc ? dec_op : WOP_NONE;

  misc_addr_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WORD_B(WORD_B), .BASE_OFF(BASE_OFF)
  ) u_dec (
    .addr(req_addr), .size(req_size), .write(req_write),
    .hit_plain(hit_plain), .bad_access(bad_access), .op(dec_op)
  );

  misc_store #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_store (
    .clk(clk), .rst(rst), .op(st_op), .wdata(req_wdata),
    .value(reg_q), .irq(irq)
  );

  misc_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst(rst),
    .rd_acc(acc && !req_write), .rd_hit(hit_plain),
    .bad_acc(acc && bad_access), .value(reg_q),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .err_flag(err_flag)
  );
endmodule

// File: rtl/misc_ctl_reg_chk.sv
module misc_ctl_reg_chk #(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [DATA_W-1:0] reg_q,
  input logic              irq
);
  localparam int LOW_W = DATA_W - KEEP_W;

  p_low_zero_r3: assert property (@(posedge clk) disable iff (rst)
    reg_q[LOW_W-1:0] == '0);

  p_rsp_low_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_rdata[LOW_W-1:0] == '0);

  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready && req_write) |=> $stable(irq));

  p_hold_rsp_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_read_rsp_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
endmodule

bind misc_ctl_reg misc_ctl_reg_chk #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .reg_q(reg_q), .irq(irq)
);

// File: tb/misc_ctl_reg_bench.sv
`timescale 1ns/100ps
module misc_ctl_reg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_size = 4'd8;
  logic [63:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, err_flag, irq;
  logic [63:0] rsp_rdata;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  misc_ctl_reg u_misc_ctl_reg (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .err_flag(err_flag), .irq(irq)
  );

  localparam logic [63:0] TOP16 = 64'hFFFF_0000_0000_0000;

  // behavioural reference model
  logic [63:0] m_reg = '0, m_rd = '0;
  logic        m_rv = 1'b0, m_err = 1'b0, m_acc = 1'b0;
  bit          cmp_on = 1'b0;

  always @(posedge clk) begin
    int off;
    bit good, mapped;
    logic [63:0] nv;
    if (rst) begin
      m_reg <= '0; m_rv <= 1'b0; m_rd <= '0; m_err <= 1'b0; m_acc <= 1'b0;
    end else begin
      m_acc <= req_valid && (!m_rv || rsp_ready);
      off    = int'(req_addr) / 8;
      good   = (req_size == 4'd8);
      mapped = (off >= 'h4020) && (off <= 'h4022);
      m_err <= (req_valid && (!m_rv || rsp_ready)) && !(good && mapped);
      if (m_rv && rsp_ready) m_rv <= 1'b0;
      if (req_valid && (!m_rv || rsp_ready)) begin
        if (!req_write) begin
          m_rv <= 1'b1;
          m_rd <= (good && off == 'h4020) ? m_reg : 64'h0;
        end else if (good) begin
          nv = m_reg;
          if (off == 'h4020) nv = req_wdata;
          if (off == 'h4021) nv = m_reg & req_wdata;
          if (off == 'h4022) nv = m_reg | req_wdata;
          m_reg <= nv & TOP16;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(rsp_valid == m_rv, "R7 rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) chk(rsp_rdata == m_rd, "R7 rsp_rdata", rsp_rdata, m_rd);
      chk(err_flag == m_err, "R8 err_flag", 64'(err_flag), 64'(m_err));
      chk(irq == m_reg[63], "R6 irq", 64'(irq), 64'(m_reg[63]));
      chk(req_ready == (!m_rv || rsp_ready), "R9 req_ready", 64'(req_ready), 64'(!m_rv || rsp_ready));
    end
  end

  function automatic logic [23:0] wa(input int off);
    return 24'(off * 8);
  endfunction

  logic [63:0] got;
  logic        got_err;

  task automatic access(input bit wr, input logic [23:0] a, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk); #1;
    req_valid = 1'b0;
    got = rsp_rdata;
    got_err = err_flag;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    rst = 1'b0;
    cmp_on = 1'b1;
    @(negedge clk); #1;
    // R10: reset state
    chk(req_ready && !irq && !err_flag && !rsp_valid, "R10 reset outputs",
        {60'd0, req_ready, irq, err_flag, rsp_valid}, 64'h8);
    access(1'b0, wa('h4020), 4'd8, 0);
    chk(got == 64'h0, "R10 reset value", got, 64'h0);

    // R2/R3: load all ones, low bits dropped
    access(1'b1, wa('h4020), 4'd8, '1);
    chk(irq == 1'b1, "R6 irq high after load", 64'(irq), 64'h1);
    access(1'b0, wa('h4020), 4'd8, 0);
    chk(got == TOP16, "R2 R3 load masked", got, TOP16);

    // R4: clear bit 63 through clear port
    access(1'b1, wa('h4021), 4'd8, 64'h7FF0_FFFF_FFFF_FFFF);
    chk(irq == 1'b0, "R6 irq low after clear", 64'(irq), 64'h0);
    access(1'b0, wa('h4020), 4'd8, 0);
    chk(got == 64'h7FF0_0000_0000_0000, "R4 clear port", got, 64'h7FF0_0000_0000_0000);

    // R5: set bits through set port
    access(1'b1, wa('h4022), 4'd8, 64'h8005_0000_0000_0001);
    access(1'b0, wa('h4020), 4'd8, 0);
    chk(got == 64'hFFF5_0000_0000_0000, "R5 set port", got, 64'hFFF5_0000_0000_0000);

    // R7: alias reads return zero without error
    access(1'b0, wa('h4021), 4'd8, 0);
    chk(got == 64'h0 && !got_err, "R7 clear port reads zero", got, 64'h0);
    access(1'b0, wa('h4022), 4'd8, 0);
    chk(got == 64'h0 && !got_err, "R7 set port reads zero", got, 64'h0);

    // R8: unmapped offset and wrong size
    access(1'b1, wa('h4023), 4'd8, 64'h0);
    chk(got_err == 1'b1, "R8 unmapped write flags", 64'(got_err), 64'h1);
    access(1'b1, wa('h4020), 4'd4, 64'h0);
    chk(got_err == 1'b1, "R8 short write flags", 64'(got_err), 64'h1);
    access(1'b0, wa('h4020), 4'd8, 0);
    chk(got == 64'hFFF5_0000_0000_0000 && !got_err, "R8 value unchanged", got, 64'hFFF5_0000_0000_0000);
    access(1'b0, wa('h401F), 4'd8, 0);
    chk(got == 64'h0 && got_err, "R8 unmapped read", got, 64'h0);

    // R1: low address bits ignored
    access(1'b1, wa('h4020) | 24'h5, 4'd8, 64'h1234_5678_0000_0000);
    access(1'b0, wa('h4020) | 24'h3, 4'd8, 0);
    chk(got == 64'h1234_0000_0000_0000, "R1 low address bits", got, 64'h1234_0000_0000_0000);

    // R9: held response blocks requests
    @(negedge clk); #1; rsp_ready = 1'b0;
    access(1'b0, wa('h4020), 4'd8, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(rsp_valid && !req_ready && rsp_rdata == 64'h1234_0000_0000_0000,
          "R9 held response", rsp_rdata, 64'h1234_0000_0000_0000);
    end
    rsp_ready = 1'b1;

    // pseudo-random traffic, model compared each clock
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      rsp_ready = ($urandom_range(0, 3) != 0);
      if (!(req_valid && !m_acc)) begin
        int pick;
        req_valid = ($urandom_range(0, 9) < 6);
        req_write = $urandom_range(0, 1);
        pick      = $urandom_range(0, 5);
        req_addr  = wa('h401F + pick) | 24'($urandom_range(0, 7));
        req_size  = ($urandom_range(0, 7) == 0) ? 4'd4 : 4'd8;
        req_wdata = {$urandom, $urandom};
      end
    end
    @(negedge clk); #1; req_valid = 1'b0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule